// File: doc/BRIEF.md
# Stream-to-Memory Receive Channel

This block is a single receive channel that moves a 64-bit data stream into memory. Software first loads a buffer base address and then a byte length through a small register port. Writing the length arms the channel. From then on, every accepted beat is written to consecutive 8-byte words starting at the base address. The programmed length limits how much data fits in the buffer, but it does not end the transfer. The transfer ends only when a beat marked last is accepted. At that point the length register is replaced by the number of bytes actually received, and a sticky completion flag is raised.

If the stream offers more data than the buffer can hold before the last beat arrives, the channel does not truncate the transfer. It consumes the offending beat without writing it, sets an internal-error flag and halts. Arming with a length of zero gives the same error. A halted channel refuses all stream data and ignores new length writes until software writes the soft-reset control bit.

The memory side is a plain word-write port with a valid/ready handshake. Backpressure on that port is passed straight back to the stream's ready.

Top module: `s2m_rx_chan`

## Requirements
- R1: After reset, the status register (offset 0x04) reads 0x0000_0002, which is the idle bit (bit 1) alone. The length register (0x28) and the base register (0x18) read 0, and s_tready_o and mem_valid_o are low.
- R2: While no transfer is running, s_tready_o stays low even when s_tvalid_i is high, and no memory write is issued.
- R3: A write to offset 0x28 with a nonzero value arms a transfer that uses the base held at 0x18. While the transfer runs, status bit 1 reads 0.
- R4: The k-th accepted beat (k from 0) is written with mem_addr_o = base + 8*k and mem_data_o equal to the beat's data.
- R5: Accepting a beat with s_tlast_i = 1 ends the transfer. Status then reads idle (bit 1) and done (bit 12), the length register reads 8 times the number of beats received even when that is below the programmed value, and s_tready_o drops.
- R6: When beats without last exactly fill the programmed length, the transfer stays running: status bit 1 = 0, bit 12 = 0, and no error is raised.
- R7: A beat that would carry the byte count past the programmed length is consumed without a memory write. It sets the error bit (bit 4) and halts the channel. While halted, s_tready_o stays low and length writes are ignored.
- R8: Writing a length of 0 sets the error bit and halts the channel without accepting any beat.
- R9: Writing 1 to bit 2 of the control register (0x00) clears the error, done, base and length state and returns the channel to idle.
- R10: Writing 1 to status bit 12 clears the done flag. Writing 0 there leaves it set.
- R11: While mem_ready_i is low, s_tready_o is low, and mem_valid_o, mem_addr_o and mem_data_o hold their values for as long as the beat is offered.
- R12: A length write during a running transfer is ignored: the length register keeps the armed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 8 | Register write byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | 8 | Register read byte offset |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| s_tvalid_i | input | 1 | Stream beat valid |
| s_tready_o | output | 1 | Stream beat ready |
| s_tdata_i | input | 64 | Stream beat data |
| s_tlast_i | input | 1 | Stream last-beat marker |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory write accept |
| mem_addr_o | output | 32 | Memory write byte address |
| mem_data_o | output | 64 | Memory write data |

## Verification
The bench targets the boundary between a buffer that is exactly full and one that overflows. A design that stopped at the programmed length would report done too early, and a design with an off-by-one compare would either flag an error on the filling beat or write the overflowing beat into memory. Short transfers check that the length readback reports the bytes received rather than the value software wrote. Other tests hold a beat under memory backpressure to catch a channel that drops or advances its address, write a length while a transfer runs, and check that a halted channel rejects both stream data and new length writes until the soft reset.

// File: rtl/s2m_rx_pkg.sv
package s2m_rx_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h04;
  localparam logic [7:0] OFF_BASE = 8'h18;
  localparam logic [7:0] OFF_LEN  = 8'h28;

  localparam int CTRL_SRST_BIT = 2;
  localparam int STAT_IDLE_BIT = 1;
  localparam int STAT_ERR_BIT  = 4;
  localparam int STAT_DONE_BIT = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } rx_state_e;
endpackage

// File: rtl/s2m_rx_csr.sv
module s2m_rx_csr
  import s2m_rx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 26,
  parameter int REG_AW = 8,
  parameter int REG_DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] waddr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic [REG_AW-1:0] raddr_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              arm_o,
  output logic [LEN_W-1:0]  arm_len_o,
  output logic              srst_o,
  output logic              done_clr_o,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              idle_i,
  input  logic              err_i,
  input  logic              done_i
);
  logic [ADDR_W-1:0] base_q;

  assign arm_o      = wr_i && (waddr_i == REG_AW'(OFF_LEN));
  assign arm_len_o  = wdata_i[LEN_W-1:0];
  assign srst_o     = wr_i && (waddr_i == REG_AW'(OFF_CTRL)) && wdata_i[CTRL_SRST_BIT];
  assign done_clr_o = wr_i && (waddr_i == REG_AW'(OFF_STAT)) && wdata_i[STAT_DONE_BIT];
  assign base_o     = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         base_q <= '0;
    else if (srst_o)                                     base_q <= '0;
    else if (wr_i && (waddr_i == REG_AW'(OFF_BASE)))     base_q <= wdata_i[ADDR_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    unique case (raddr_i)
      REG_AW'(OFF_STAT): begin
        rdata_o[STAT_IDLE_BIT] = idle_i;
        rdata_o[STAT_ERR_BIT]  = err_i;
        rdata_o[STAT_DONE_BIT] = done_i;
      end
      REG_AW'(OFF_BASE): rdata_o[ADDR_W-1:0] = base_q;
      REG_AW'(OFF_LEN):  rdata_o[LEN_W-1:0]  = len_i;
      default:           rdata_o = '0;
    endcase
  end

  // R9: soft reset wipes the base register
  p_srst_clears_base_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> (base_q == '0));
endmodule

// File: rtl/s2m_rx_engine.sv
module s2m_rx_engine
  import s2m_rx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 26,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [LEN_W-1:0]  arm_len_i,
  input  logic              srst_i,
  input  logic              done_clr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic              s_tlast_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              idle_o,
  output logic              err_o,
  output logic              done_o
);
  localparam int BYTES = DATA_W / 8;
  localparam int BSH   = $clog2(BYTES);

  rx_state_e         state_q;
  logic [LEN_W-1:0]  cnt_q, len_q;
  logic [ADDR_W-1:0] base_q;
  logic              err_q, done_q;
  logic [LEN_W:0]    cnt_nxt;
  logic              run, fits, fire;

  assign run     = (state_q == ST_RUN);
  assign cnt_nxt = {1'b0, cnt_q} + (LEN_W+1)'(BYTES);
  assign fits    = (cnt_nxt <= {1'b0, len_q});
  // an overflowing beat is dropped, so it need not wait on memory
  assign s_tready_o  = run && (fits ? mem_ready_i : 1'b1);
  assign mem_valid_o = run && s_tvalid_i && fits;
  assign mem_addr_o  = base_q + ADDR_W'(cnt_q);
  assign mem_data_o  = s_tdata_i;
  assign fire        = s_tvalid_i && s_tready_o;

  assign len_o  = len_q;
  assign idle_o = !run;
  assign err_o  = err_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      base_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else if (srst_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      base_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (done_clr_i) done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (arm_i) begin
          if (arm_len_i == '0) begin
            err_q   <= 1'b1;
            state_q <= ST_HALT;
          end else begin
            len_q   <= arm_len_i;
            base_q  <= base_i;
            cnt_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: if (fire) begin
          if (!fits) begin
            err_q   <= 1'b1;
            state_q <= ST_HALT;
          end else begin
            cnt_q <= cnt_nxt[LEN_W-1:0];
            if (s_tlast_i) begin
              len_q   <= cnt_nxt[LEN_W-1:0];
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  p_idle_no_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |-> !s_tready_o);

  p_arm_starts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && arm_i && !srst_i && arm_len_i != '0) |=> run);

  p_done_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (len_q != '0 && len_q[BSH-1:0] == '0 && state_q == ST_IDLE));

  p_overrun_halts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && fire && !mem_valid_o && !srst_i) |=> (err_q && state_q == ST_HALT));

  p_zero_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && arm_i && !srst_i && arm_len_i == '0) |=> (err_q && !s_tready_o));

  p_backpressure_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |-> !s_tready_o);

  p_busy_len_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && arm_i && !fire && !srst_i) |=> $stable(len_q));
endmodule

// File: rtl/s2m_rx_chan.sv
module s2m_rx_chan
  import s2m_rx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 26,
  parameter int DATA_W = 64,
  parameter int REG_AW = 8,
  parameter int REG_DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_waddr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  input  logic [REG_AW-1:0] reg_raddr_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic              s_tlast_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  logic [ADDR_W-1:0] base;
  logic              arm, srst, done_clr, idle, err, done;
  logic [LEN_W-1:0]  arm_len, len;

  s2m_rx_csr #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_AW(REG_AW), .REG_DW(REG_DW)
  ) csr_i (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .waddr_i(reg_waddr_i), .wdata_i(reg_wdata_i),
    .raddr_i(reg_raddr_i), .rdata_o(reg_rdata_o),
    .base_o(base), .arm_o(arm), .arm_len_o(arm_len),
    .srst_o(srst), .done_clr_o(done_clr),
    .len_i(len), .idle_i(idle), .err_i(err), .done_i(done)
  );

  s2m_rx_engine #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
  ) eng_i (
    .clk_i, .rst_ni,
    .arm_i(arm), .arm_len_i(arm_len), .srst_i(srst), .done_clr_i(done_clr),
    .base_i(base),
    .s_tvalid_i, .s_tready_o, .s_tdata_i, .s_tlast_i,
    .mem_valid_o, .mem_ready_i, .mem_addr_o, .mem_data_o,
    .len_o(len), .idle_o(idle), .err_o(err), .done_o(done)
  );
endmodule

// File: tb/s2m_rx_chan_tb_top.sv
module s2m_rx_chan_tb_top;
  localparam logic [31:0] ST_IDLE = 32'h0000_0002;
  localparam logic [31:0] ST_ERR  = 32'h0000_0010;
  localparam logic [31:0] ST_DONE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        s_tvalid = 1'b0, s_tready, s_tlast = 1'b0;
  logic [63:0] s_tdata = '0, mem_data;
  logic        mem_valid, mem_ready = 1'b1;
  logic [31:0] mem_addr;

  int n_chk = 0, n_err = 0, cap_n = 0;
  bit finished = 1'b0;
  logic [31:0] cap_a [0:31];
  logic [63:0] cap_d [0:31];

  always #10 clk = ~clk;

  s2m_rx_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_waddr_i(reg_waddr), .reg_wdata_i(reg_wdata),
    .reg_raddr_i(reg_raddr), .reg_rdata_o(reg_rdata),
    .s_tvalid_i(s_tvalid), .s_tready_o(s_tready), .s_tdata_i(s_tdata), .s_tlast_i(s_tlast),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  always @(posedge clk)
    if (rst_n && mem_valid && mem_ready && cap_n < 32) begin
      cap_a[cap_n] = mem_addr;
      cap_d[cap_n] = mem_data;
      cap_n++;
    end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    reg_raddr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic send_beat(logic [63:0] d, logic last, output bit acc);
    bit ok;
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = d; s_tlast = last;
    acc = 1'b0;
    for (int i = 0; i < 20; i++) begin
      #1;
      ok = s_tready;
      @(negedge clk);
      if (ok) begin acc = 1'b1; break; end
    end
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h04, v); chk("R1", "status", v, ST_IDLE);
    rd(8'h28, v); chk("R1", "length", v, 0);
    rd(8'h18, v); chk("R1", "base", v, 0);
    chk("R1", "tready", s_tready, 0);
    chk("R1", "mem_valid", mem_valid, 0);
  endtask

  task automatic t_idle_no_ready;
    int n0 = cap_n;
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = 64'hDEAD;
    for (int i = 0; i < 4; i++) begin
      #1; chk("R2", "tready while idle", s_tready, 0);
      @(negedge clk);
    end
    s_tvalid = 1'b0;
    chk("R2", "no write while idle", cap_n, n0);
  endtask

  task automatic t_basic;
    logic [31:0] v; bit acc; int n0;
    wr(8'h18, 32'h0000_1000);
    wr(8'h28, 32'd64);
    rd(8'h04, v); chk("R3", "status running", v, 0);
    n0 = cap_n;
    for (int k = 0; k < 3; k++) begin
      send_beat(64'hA000_0000_0000_0000 + 64'(k), k == 2, acc);
      chk("R4", "beat accepted", acc, 1);
    end
    chk("R4", "write count", cap_n - n0, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R4", "addr", cap_a[n0+k], 32'h1000 + 32'(8*k));
      chk("R4", "data", cap_d[n0+k], 64'hA000_0000_0000_0000 + 64'(k));
    end
    rd(8'h04, v); chk("R5", "status done", v, ST_IDLE | ST_DONE);
    rd(8'h28, v); chk("R5", "received length", v, 24);
    s_tvalid = 1'b1; #1;
    chk("R5", "tready after last", s_tready, 0);
    s_tvalid = 1'b0;
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(8'h04, 32'h0);
    rd(8'h04, v); chk("R10", "done kept on 0 write", v, ST_IDLE | ST_DONE);
    wr(8'h04, ST_DONE);
    rd(8'h04, v); chk("R10", "done cleared", v, ST_IDLE);
  endtask

  task automatic t_busy_write;
    logic [31:0] v; bit acc;
    wr(8'h18, 32'h0000_3000);
    wr(8'h28, 32'd64);
    wr(8'h28, 32'd8);
    rd(8'h28, v); chk("R12", "length kept while running", v, 64);
    rd(8'h04, v); chk("R12", "still running", v, 0);
    send_beat(64'h55, 1'b1, acc);
    rd(8'h28, v); chk("R5", "short transfer length", v, 8);
    wr(8'h04, ST_DONE);
  endtask

  task automatic t_overrun;
    logic [31:0] v; bit acc; int n0;
    wr(8'h18, 32'h0000_4000);
    wr(8'h28, 32'd16);
    n0 = cap_n;
    send_beat(64'h11, 1'b0, acc);
    send_beat(64'h22, 1'b0, acc);
    rd(8'h04, v); chk("R6", "exact fill keeps running", v, 0);
    chk("R6", "two writes", cap_n - n0, 2);
    send_beat(64'h33, 1'b0, acc);
    chk("R7", "overflow beat consumed", acc, 1);
    chk("R7", "overflow beat not written", cap_n - n0, 2);
    rd(8'h04, v); chk("R7", "error status", v, ST_IDLE | ST_ERR);
    wr(8'h28, 32'd64);
    @(negedge clk);
    s_tvalid = 1'b1; #1;
    chk("R7", "halted tready", s_tready, 0);
    s_tvalid = 1'b0;
    rd(8'h04, v); chk("R7", "length write ignored when halted", v, ST_IDLE | ST_ERR);
  endtask

  task automatic t_soft_reset;
    logic [31:0] v;
    wr(8'h00, 32'h4);
    rd(8'h04, v); chk("R9", "status after soft reset", v, ST_IDLE);
    rd(8'h18, v); chk("R9", "base after soft reset", v, 0);
    rd(8'h28, v); chk("R9", "length after soft reset", v, 0);
  endtask

  task automatic t_zero_len;
    logic [31:0] v; int n0 = cap_n;
    wr(8'h28, 32'd0);
    rd(8'h04, v); chk("R8", "zero length error", v, ST_IDLE | ST_ERR);
    @(negedge clk);
    s_tvalid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1; chk("R8", "no beat accepted", s_tready, 0);
      @(negedge clk);
    end
    s_tvalid = 1'b0;
    chk("R8", "no write", cap_n, n0);
    wr(8'h00, 32'h4);
  endtask

  task automatic t_backpressure;
    logic [31:0] v; bit acc; int n0;
    mem_ready = 1'b0;
    wr(8'h18, 32'h0000_2000);
    wr(8'h28, 32'd32);
    n0 = cap_n;
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = 64'hBEEF; s_tlast = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R11", "tready low", s_tready, 0);
      chk("R11", "valid held", mem_valid, 1);
      chk("R11", "addr held", mem_addr, 32'h2000);
      chk("R11", "data held", mem_data, 64'hBEEF);
      @(negedge clk);
    end
    mem_ready = 1'b1;
    #1; chk("R11", "tready follows ready", s_tready, 1);
    @(negedge clk);
    s_tvalid = 1'b0;
    send_beat(64'hCAFE, 1'b1, acc);
    chk("R11", "writes after release", cap_n - n0, 2);
    chk("R4", "second addr", cap_a[n0+1], 32'h2008);
    rd(8'h28, v); chk("R5", "length after backpressure", v, 16);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_no_ready();
    t_basic();
    t_w1c();
    t_busy_write();
    t_overrun();
    t_soft_reset();
    t_zero_len();
    t_backpressure();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule